// File: doc/BRIEF.md
# Display RAM Host Port with Posted Writes and Pipelined Reads

This block connects an 8-bit parallel host bus to a byte-wide display memory of 10 pages by 132 columns. The strobe protocol is set by one pin. In strobe mode, separate active-low read and write strobes control the bus. In enable mode, one enable strobe is qualified by a read/not-write line. A single register-select line chooses between display data and a command byte. Command bytes set the page register, set the column register one nibble at a time, and switch the column-to-segment mirroring. A status read returns a busy flag and the mirror setting.

Writes are posted. The byte is caught in a holding register and written to memory on the next clock. Reads go through a one-deep holder. Each data read returns the byte that the previous read fetched, and then fetches the byte at the current address. Software must therefore issue one dummy read after changing the address or after a write. The column register advances after every data access and stops at the last column. A scan port lets the display side read any byte by segment index, with the mirror setting applied.

All bus pins are treated as synchronous to `clk`. An access takes effect in the cycle after its strobe is seen to end.

Top module: `lcd_host_port`

## Requirements
- R1: After a synchronous active-low reset, the page is 0, the column is 0, mirroring is off, the read holder holds 0x00, nothing is posted, and `dout_oe` is low.
- R2: The chip responds only while `cs1_n` is 0 and `cs2` is 1. At any other time `dout_oe` stays low, and strobes change nothing: no memory byte, no column, no page and no mode.
- R3: When `bus_mode` is 0, `rd_e` and `wr_rw` are active-low read and write strobes. When `bus_mode` is 1, `rd_e` is an active-high enable and `wr_rw` is 1 for a read and 0 for a write. A write takes effect when its strobe ends: the rising edge of the write strobe, or the falling edge of the enable.
- R4: Writes with `a0`=0 are commands:
  - 0xB0 plus p sets the page to p.
  - 0x1h sets column bits 7..4 to h.
  - 0x0l sets column bits 3..0 to l.
  - 0xA1 turns mirroring on and 0xA0 turns it off.
  - Any other byte is ignored.
- R5: A page command with p of 10 or more is ignored, and the previous page is kept.
- R6: A write with `a0`=1 captures the byte into a holding register and commits it to memory at the current page and column one clock later. The busy flag is 1 during exactly that one cycle.
- R7: A read with `a0`=1 drives the holder onto `dout` while the strobe is active. When the strobe ends, the holder is reloaded from the current page and column. The first read after an address change or a write therefore returns a stale byte.
- R8: The column advances by one after each data read or data write, and stays at 0x83 once it gets there. A column command whose result would exceed 0x83 sets the column to 0x83.
- R9: A read with `a0`=0 returns the status byte: bit 7 is busy, bit 6 is the mirror setting, and bits 5..0 are zero. It changes neither the column nor the holder.
- R10: `scan_data` is the memory byte at `scan_page` and column `scan_seg` when mirroring is off, or column 131 − `scan_seg` when it is on. A committed write is visible there from the cycle after the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_mode | input | 1 | 0: separate strobes, 1: enable plus read/not-write |
| cs1_n | input | 1 | Chip select, active low |
| cs2 | input | 1 | Chip select, active high |
| a0 | input | 1 | 1: display data, 0: command or status |
| rd_e | input | 1 | Read strobe (active low) or enable (active high) |
| wr_rw | input | 1 | Write strobe (active low) or read/not-write |
| din | input | 8 | Byte from the host |
| dout | output | 8 | Byte to the host |
| dout_oe | output | 1 | High while the block drives the host bus |
| scan_page | input | 4 | Page index on the scan side |
| scan_seg | input | 8 | Segment index on the scan side |
| scan_data | output | 8 | Memory byte for the scan address |

## Verification
The posted commit of a data write can happen in the same cycle as a host status read. It can also happen while the scan port is pointed at the byte being written.

The bench provokes both cases at once. It ends a data write and, in the very next cycle, starts a status read with the scan address held on the target byte. Before the commit edge, it expects busy set and the old byte on `scan_data`. One cycle later, it expects busy clear and the new byte.

// File: rtl/lcd_host_pkg.sv
// Package: command codes and the bus protocol selector shared by the host port.
// Assumes command bytes carry an opcode in the upper nibble and an argument in the lower nibble.
package lcd_host_pkg;

    typedef enum logic {
        BUS_STROBES = 1'b0,
        BUS_ENABLE  = 1'b1
    } bus_mode_e;

    localparam logic [3:0] OP_PAGE   = 4'hB;
    localparam logic [3:0] OP_COL_HI = 4'h1;
    localparam logic [3:0] OP_COL_LO = 4'h0;
    localparam logic [7:0] OP_MIR_OFF = 8'hA0;
    localparam logic [7:0] OP_MIR_ON  = 8'hA1;

endpackage

// File: rtl/lcd_bus_strobe.sv
// Module: turns the host pins into access-active and access-end events for either bus protocol.
// Assumes all pins are synchronous to clk. The last active cycle's a0 and data are kept for the end event.
module lcd_bus_strobe
    import lcd_host_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_i,
    input  logic          sel_i,
    input  logic          rde_i,
    input  logic          wrrw_i,
    input  logic          a0_i,
    input  logic [DW-1:0] din_i,
    output logic          rd_act_o,
    output logic          wr_end_o,
    output logic          rd_end_o,
    output logic          a0_o,
    output logic [DW-1:0] din_o
);

    logic raw_rd, raw_wr;
    logic prev_rd_q, prev_wr_q;
    logic cap_a0_q;
    logic [DW-1:0] cap_din_q;

    // Decode the raw access phase from the pins for the selected protocol.
    always_comb begin
        if (bus_mode_e'(mode_i) == BUS_ENABLE) begin
            raw_rd = rde_i & wrrw_i;
            raw_wr = rde_i & ~wrrw_i;
        end else begin
            raw_rd = ~rde_i;
            raw_wr = ~wrrw_i & rde_i;
        end
    end

    // Remember the access phase and the operands of the last selected active cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_rd_q <= 1'b0;
            prev_wr_q <= 1'b0;
            cap_a0_q  <= 1'b0;
            cap_din_q <= '0;
        end else begin
            prev_rd_q <= sel_i & raw_rd;
            prev_wr_q <= sel_i & raw_wr;
            if (sel_i && (raw_rd || raw_wr)) begin
                cap_a0_q  <= a0_i;
                cap_din_q <= din_i;
            end
        end
    end

    assign rd_act_o = sel_i & raw_rd;
    assign wr_end_o = sel_i & prev_wr_q & ~raw_wr;
    assign rd_end_o = sel_i & prev_rd_q & ~raw_rd;
    assign a0_o     = cap_a0_q;
    assign din_o    = cap_din_q;

    AST_END_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_end_o && rd_end_o)); // R3

endmodule

// File: rtl/lcd_addr_regs.sv
// Module: page, column and mirror registers with the command decoder that sets them.
// Assumes a command strobe and a data-access step never occur in the same cycle.
module lcd_addr_regs
    import lcd_host_pkg::*;
#(
    parameter int PAGES = 10,
    parameter int COLS  = 132,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_stb_i,
    input  logic [DW-1:0]              cmd_i,
    input  logic                       step_i,
    output logic [$clog2(PAGES)-1:0]   page_o,
    output logic [$clog2(COLS)-1:0]    col_o,
    output logic                       mirror_o
);

    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(COLS);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [3:0]    PAGE_LIM = 4'(PAGES);

    logic [PW-1:0] page_q;
    logic [CW-1:0] col_q;
    logic          mirror_q;
    logic [CW-1:0] hi_val, lo_val, hi_sat, lo_sat;

    // Form the column values that the nibble commands would produce, clamped to the last column.
    always_comb begin
        hi_val = col_q;
        hi_val[CW-1:4] = cmd_i[CW-5:0];
        lo_val = col_q;
        lo_val[3:0] = cmd_i[3:0];
        hi_sat = (hi_val > LAST_COL) ? LAST_COL : hi_val;
        lo_sat = (lo_val > LAST_COL) ? LAST_COL : lo_val;
    end

    // Apply commands, otherwise advance the column after a data access until it saturates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q   <= '0;
            col_q    <= '0;
            mirror_q <= 1'b0;
        end else if (cmd_stb_i) begin
            if (cmd_i[7:4] == OP_PAGE) begin
                if (cmd_i[3:0] < PAGE_LIM) page_q <= PW'(cmd_i[3:0]);
            end else if (cmd_i[7:4] == OP_COL_HI) begin
                col_q <= hi_sat;
            end else if (cmd_i[7:4] == OP_COL_LO) begin
                col_q <= lo_sat;
            end else if (cmd_i == OP_MIR_ON) begin
                mirror_q <= 1'b1;
            end else if (cmd_i == OP_MIR_OFF) begin
                mirror_q <= 1'b0;
            end
        end else if (step_i && (col_q != LAST_COL)) begin
            col_q <= col_q + 1'b1;
        end
    end

    assign page_o   = page_q;
    assign col_o    = col_q;
    assign mirror_o = mirror_q;

    AST_PAGE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        page_q < PW'(PAGES)); // R5
    AST_BAD_PAGE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_stb_i && cmd_i[7:4] == OP_PAGE && cmd_i[3:0] >= PAGE_LIM) |=> $stable(page_q)); // R5
    AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= LAST_COL); // R8
    AST_COL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !cmd_stb_i && col_q == LAST_COL) |=> (col_q == LAST_COL)); // R8
    AST_NO_CMD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_i && cmd_stb_i)); // R4

endmodule

// File: rtl/lcd_page_ram.sv
// Module: the page-by-column byte store with one write port, one host read port and a mirrored scan port.
// Assumes the write address is always in range. Scan reads outside the array return zero.
module lcd_page_ram #(
    parameter int PAGES = 10,
    parameter int COLS  = 132,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       we_i,
    input  logic [$clog2(PAGES)-1:0]   wpage_i,
    input  logic [$clog2(COLS)-1:0]    wcol_i,
    input  logic [DW-1:0]              wdata_i,
    input  logic [$clog2(PAGES)-1:0]   rpage_i,
    input  logic [$clog2(COLS)-1:0]    rcol_i,
    output logic [DW-1:0]              rdata_o,
    input  logic                       mirror_i,
    input  logic [$clog2(PAGES)-1:0]   spage_i,
    input  logic [$clog2(COLS)-1:0]    sseg_i,
    output logic [DW-1:0]              sdata_o
);

    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(COLS);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);
    localparam logic [PW-1:0] PAGE_LIM = PW'(PAGES);

    logic [DW-1:0] mem [PAGES][COLS];
    logic [CW-1:0] scol;

    // Store a committed byte.
    always_ff @(posedge clk) begin
        if (we_i) mem[wpage_i][wcol_i] <= wdata_i;
    end

    // Host-side read of the current address.
    always_comb begin
        if (rpage_i < PAGE_LIM && rcol_i <= LAST_COL) rdata_o = mem[rpage_i][rcol_i];
        else rdata_o = '0;
    end

    // Scan-side read with the segment index mapped through the mirror setting.
    always_comb begin
        scol = mirror_i ? (LAST_COL - sseg_i) : sseg_i;
        if (spage_i < PAGE_LIM && sseg_i <= LAST_COL) sdata_o = mem[spage_i][scol];
        else sdata_o = '0;
    end

    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (wpage_i < PAGE_LIM && wcol_i <= LAST_COL)); // R6

endmodule

// File: rtl/lcd_host_port.sv
// Module: top of the host port. It posts data writes through a holding register, pipelines data
// reads through a one-deep holder, and returns status on command reads.
// Assumes host strobes last at least one clock and are separated by at least one idle clock.
module lcd_host_port
    import lcd_host_pkg::*;
#(
    parameter int PAGES = 10,
    parameter int COLS  = 132,
    parameter int DW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_mode,
    input  logic                       cs1_n,
    input  logic                       cs2,
    input  logic                       a0,
    input  logic                       rd_e,
    input  logic                       wr_rw,
    input  logic [DW-1:0]              din,
    output logic [DW-1:0]              dout,
    output logic                       dout_oe,
    input  logic [$clog2(PAGES)-1:0]   scan_page,
    input  logic [$clog2(COLS)-1:0]    scan_seg,
    output logic [DW-1:0]              scan_data
);

    localparam int PW = $clog2(PAGES);
    localparam int CW = $clog2(COLS);

    logic          sel;
    logic          rd_act, wr_end, rd_end, cap_a0;
    logic [DW-1:0] cap_din;
    logic          wr_data_ev, rd_data_ev, cmd_ev;
    logic [PW-1:0] page;
    logic [CW-1:0] col;
    logic          mirror;
    logic [DW-1:0] ram_rdata;
    logic          wpend_q;
    logic [PW-1:0] wpage_q;
    logic [CW-1:0] wcol_q;
    logic [DW-1:0] wbuf_q;
    logic [DW-1:0] holder_q;
    logic [DW-1:0] status;

    assign sel = ~cs1_n & cs2;

    lcd_bus_strobe #(.DW(DW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (bus_mode),
        .sel_i    (sel),
        .rde_i    (rd_e),
        .wrrw_i   (wr_rw),
        .a0_i     (a0),
        .din_i    (din),
        .rd_act_o (rd_act),
        .wr_end_o (wr_end),
        .rd_end_o (rd_end),
        .a0_o     (cap_a0),
        .din_o    (cap_din)
    );

    assign wr_data_ev = wr_end & cap_a0;
    assign cmd_ev     = wr_end & ~cap_a0;
    assign rd_data_ev = rd_end & cap_a0;

    lcd_addr_regs #(.PAGES(PAGES), .COLS(COLS), .DW(DW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_stb_i (cmd_ev),
        .cmd_i     (cap_din),
        .step_i    (wr_data_ev | rd_data_ev),
        .page_o    (page),
        .col_o     (col),
        .mirror_o  (mirror)
    );

    lcd_page_ram #(.PAGES(PAGES), .COLS(COLS), .DW(DW)) u_ram (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (wpend_q),
        .wpage_i  (wpage_q),
        .wcol_i   (wcol_q),
        .wdata_i  (wbuf_q),
        .rpage_i  (page),
        .rcol_i   (col),
        .rdata_o  (ram_rdata),
        .mirror_i (mirror),
        .spage_i  (scan_page),
        .sseg_i   (scan_seg),
        .sdata_o  (scan_data)
    );

    // Post a data write: latch byte and address now, commit on the following clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wpend_q <= 1'b0;
            wpage_q <= '0;
            wcol_q  <= '0;
            wbuf_q  <= '0;
        end else begin
            wpend_q <= wr_data_ev;
            if (wr_data_ev) begin
                wpage_q <= page;
                wcol_q  <= col;
                wbuf_q  <= cap_din;
            end
        end
    end

    // Refill the read holder from the current address when a data read ends.
    always_ff @(posedge clk) begin
        if (!rst_n) holder_q <= '0;
        else if (rd_data_ev) holder_q <= ram_rdata;
    end

    // Status byte: busy on the top bit, mirror setting next, the rest zero.
    always_comb begin
        status = '0;
        status[DW-1] = wpend_q;
        status[DW-2] = mirror;
    end

    assign dout    = a0 ? holder_q : status;
    assign dout_oe = rd_act;

    AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs1_n && cs2) |-> !(wr_end || rd_end || dout_oe)); // R2
    AST_POST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wpend_q |=> !wpend_q); // R6
    AST_POST_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_data_ev |=> wpend_q); // R6
    AST_NO_READ_IN_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_ev |-> !wpend_q); // R7
    AST_STATUS_KEEPS_HOLDER: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_end && !cap_a0) |=> $stable(holder_q)); // R9

endmodule

// File: tb/lcd_host_port_tb.sv
// Directed bench: one task per scenario, each checking its own results at the ports.
module lcd_host_port_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_mode = 1'b0;
    logic       cs1_n = 1'b0;
    logic       cs2 = 1'b1;
    logic       a0 = 1'b0;
    logic       rd_e = 1'b1;
    logic       wr_rw = 1'b1;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       dout_oe;
    logic [3:0] scan_page = 4'd0;
    logic [7:0] scan_seg = 8'd0;
    logic [7:0] scan_data;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lcd_host_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_mode  (bus_mode),
        .cs1_n     (cs1_n),
        .cs2       (cs2),
        .a0        (a0),
        .rd_e      (rd_e),
        .wr_rw     (wr_rw),
        .din       (din),
        .dout      (dout),
        .dout_oe   (dout_oe),
        .scan_page (scan_page),
        .scan_seg  (scan_seg),
        .scan_data (scan_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_wr(input logic av, input logic [7:0] d);
        @(negedge clk);
        a0 = av; din = d;
        if (bus_mode) begin wr_rw = 1'b0; rd_e = 1'b1; end
        else wr_rw = 1'b0;
        @(negedge clk);
        if (bus_mode) rd_e = 1'b0;
        else wr_rw = 1'b1;
        @(negedge clk);
        wr_rw = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_rd(input logic av, output logic [7:0] d, output logic oe);
        @(negedge clk);
        a0 = av;
        if (bus_mode) begin wr_rw = 1'b1; rd_e = 1'b1; end
        else rd_e = 1'b0;
        #(CLK_PERIOD/4);
        d = dout; oe = dout_oe;
        @(negedge clk);
        rd_e = bus_mode ? 1'b0 : 1'b1;
        @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] b);
        bus_wr(1'b0, b);
    endtask

    task automatic set_col(input logic [7:0] c);
        cmd({4'h1, c[7:4]});
        cmd({4'h0, c[3:0]});
    endtask

    task automatic scan(input logic [3:0] p, input logic [7:0] s, output logic [7:0] d);
        @(negedge clk);
        scan_page = p; scan_seg = s;
        #1;
        d = scan_data;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        cs1_n = 1'b1;
        bus_mode = m;
        rd_e = m ? 1'b0 : 1'b1;
        wr_rw = 1'b1;
        @(negedge clk);
        @(negedge clk);
        cs1_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic oe;
        chk("R1 oe idle", {7'd0, dout_oe}, 8'h00);
        bus_rd(1'b0, d, oe);
        chk("R1 R9 status after reset", d, 8'h00);
        chk("R2 oe during read", {7'd0, oe}, 8'h01);
    endtask

    task automatic t_basic();
        logic [7:0] d; logic oe;
        cmd(8'hB2);
        set_col(8'h05);
        bus_wr(1'b1, 8'h11);
        bus_wr(1'b1, 8'h22);
        bus_wr(1'b1, 8'h33);
        scan(4'd2, 8'd5, d); chk("R6 R10 commit col5", d, 8'h11);
        scan(4'd2, 8'd6, d); chk("R8 commit col6", d, 8'h22);
        scan(4'd2, 8'd7, d); chk("R8 commit col7", d, 8'h33);
        set_col(8'h05);
        bus_rd(1'b1, d, oe); chk("R1 R7 dummy returns reset holder", d, 8'h00);
        bus_rd(1'b1, d, oe); chk("R7 first real read", d, 8'h11);
        bus_rd(1'b1, d, oe); chk("R7 R8 second read", d, 8'h22);
        bus_wr(1'b1, 8'h44);
        bus_rd(1'b1, d, oe); chk("R7 stale read after write", d, 8'h33);
        scan(4'd2, 8'd8, d); chk("R8 write after reads at col8", d, 8'h44);
    endtask

    task automatic t_enable_mode();
        logic [7:0] d; logic oe;
        set_mode(1'b1);
        cmd(8'hB3);
        set_col(8'h10);
        bus_wr(1'b1, 8'hA5);
        bus_wr(1'b1, 8'h5A);
        scan(4'd3, 8'h10, d); chk("R3 enable-mode write", d, 8'hA5);
        set_col(8'h10);
        bus_rd(1'b1, d, oe);
        bus_rd(1'b1, d, oe); chk("R3 enable-mode read", d, 8'hA5);
        bus_rd(1'b1, d, oe); chk("R3 enable-mode read next", d, 8'h5A);
        bus_rd(1'b0, d, oe); chk("R3 R9 enable-mode status", d, 8'h00);
        set_mode(1'b0);
    endtask

    task automatic t_mirror();
        logic [7:0] d; logic oe;
        cmd(8'hA1);
        bus_rd(1'b0, d, oe); chk("R9 status mirror bit", d, 8'h40);
        scan(4'd2, 8'd126, d); chk("R10 mirrored seg126", d, 8'h11);
        scan(4'd2, 8'd124, d); chk("R10 mirrored seg124", d, 8'h33);
        cmd(8'hA0);
        scan(4'd2, 8'd5, d); chk("R10 unmirrored seg5", d, 8'h11);
        cmd(8'hC7);
        bus_rd(1'b0, d, oe); chk("R4 unknown command ignored", d, 8'h00);
    endtask

    task automatic t_pages();
        logic [7:0] d;
        cmd(8'hB3);
        cmd(8'hBC);
        set_col(8'h20);
        bus_wr(1'b1, 8'h77);
        scan(4'd3, 8'h20, d); chk("R5 bad page kept page3", d, 8'h77);
        cmd(8'hB9);
        set_col(8'h00);
        bus_wr(1'b1, 8'h99);
        scan(4'd9, 8'h00, d); chk("R4 last valid page", d, 8'h99);
    endtask

    task automatic t_saturate();
        logic [7:0] d;
        cmd(8'hB4);
        set_col(8'h82);
        bus_wr(1'b1, 8'hC1);
        bus_wr(1'b1, 8'hC2);
        bus_wr(1'b1, 8'hC3);
        scan(4'd4, 8'h82, d); chk("R8 before last column", d, 8'hC1);
        scan(4'd4, 8'h83, d); chk("R8 column held at 0x83", d, 8'hC3);
        cmd(8'h19);
        bus_wr(1'b1, 8'h44);
        scan(4'd4, 8'h83, d); chk("R8 column set clamped", d, 8'h44);
    endtask

    task automatic t_deselect();
        logic [7:0] d; logic oe;
        cmd(8'hB4);
        set_col(8'h10);
        bus_wr(1'b1, 8'h5E);
        cs1_n = 1'b1;
        bus_wr(1'b1, 8'hEE);
        cmd(8'hB0);
        bus_rd(1'b0, d, oe); chk("R2 no drive when cs1_n high", {7'd0, oe}, 8'h00);
        cs1_n = 1'b0;
        bus_wr(1'b1, 8'h6F);
        scan(4'd4, 8'h10, d); chk("R2 deselected write dropped", d, 8'h5E);
        scan(4'd4, 8'h11, d); chk("R2 column and page unmoved", d, 8'h6F);
        cs2 = 1'b0;
        bus_wr(1'b1, 8'hEE);
        cs2 = 1'b1;
        bus_wr(1'b1, 8'h70);
        scan(4'd4, 8'h12, d); chk("R2 cs2 low ignored", d, 8'h70);
        scan(4'd4, 8'h11, d); chk("R2 cs2 low no write", d, 8'h6F);
    endtask

    task automatic t_overlap();
        cmd(8'hB5);
        set_col(8'h00);
        bus_wr(1'b1, 8'h12);
        set_col(8'h00);
        @(negedge clk);
        scan_page = 4'd5; scan_seg = 8'd0;
        a0 = 1'b1; din = 8'h34; wr_rw = 1'b0;
        @(negedge clk);
        wr_rw = 1'b1;
        @(negedge clk);
        a0 = 1'b0; rd_e = 1'b0;
        #(CLK_PERIOD/4);
        chk("R6 R9 busy while posted", dout, 8'h80);
        chk("R10 old byte before commit", scan_data, 8'h12);
        @(negedge clk);
        #(CLK_PERIOD/4);
        chk("R6 busy clear after commit", dout, 8'h00);
        chk("R6 R10 new byte after commit", scan_data, 8'h34);
        @(negedge clk);
        rd_e = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_enable_mode();
        t_mirror();
        t_pages();
        t_saturate();
        t_deselect();
        t_overlap();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule